// File: doc/BRIEF.md
# Posted Write Store Buffer

This block sits between a processor's write port and one external bus master port. Writes that are allowed to complete late are posted into a small first-in first-out queue. The core can then carry on while the queue empties onto the bus, one request at a time, in the order the writes were accepted. Whether a write may be posted depends on three things: a software-controlled enable bit, the memory type of the region being written, and whether the access asks for precise or imprecise completion.

A write that is not posted goes to the bus directly. This is a bypass. The core is stalled until the bus acknowledges that write. A bypass is only presented on the bus once every posted entry has drained, so the bus always sees writes in program order. Synchronizing code can watch the empty flag to learn that every posted write has completed.

Top module: `pwb_top`

## Requirements
- R1: After reset the enable bit is clear, `buf_empty` is 1 and `bus_req` is 0.
- R2: When the queue holds four entries and a write that would be posted is requested, `cpu_ready` stays 0 until an entry has drained.
- R3: While the enable bit is clear, every write is a bypass. With the queue empty, the bus shows the core's address, data and byte enables with `bus_req` = 1, and `cpu_ready` equals `bus_ack`.
- R4: While the enable bit is set, a write is posted if `cpu_mode` is 2'b01 (write-through), or if `cpu_mode` is 2'b10 or 2'b11 (cache-inhibited) with `cpu_precise` = 0. A posted write is accepted with `cpu_ready` = 1 without waiting for the bus.
- R5: A cache-inhibited write with `cpu_precise` = 1, or a write with `cpu_mode` = 2'b00 (copyback), is a bypass even when the enable bit is set.
- R6: While the queue is not empty, a bypass write is held (`cpu_ready` = 0), and the bus shows the oldest queued entry instead.
- R7: Queued entries reach the bus in acceptance order, with address, 32-bit data and 4 byte-enable bits unchanged.
- R8: An entry is removed only in a cycle where `bus_ack` = 1. While `bus_req` = 1 and `bus_ack` = 0, the presented entry stays stable.
- R9: Writing 0 to the enable bit (`ctl_wr` = 1, `ctl_en` = 0) while entries are pending keeps them. They drain in order before a later bypass is issued.
- R10: `buf_empty` is 1 exactly when no posted write remains in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Load strobe for the enable bit |
| ctl_en | input | 1 | New value of the enable bit |
| cpu_req | input | 1 | Core write request, held until accepted |
| cpu_addr | input | AW | Write address |
| cpu_data | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables |
| cpu_mode | input | 2 | Region type: 00 copyback, 01 write-through, 1x cache-inhibited |
| cpu_precise | input | 1 | 1 = precise completion required |
| cpu_ready | output | 1 | Write accepted this cycle |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | AW | Bus write address |
| bus_data | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_ack | input | 1 | Bus accepts the presented write |
| buf_empty | output | 1 | No posted write pending |

## Verification
The routing decision is swept over every region code and both precision settings, with the enable bit both clear and set. The same write therefore shows either an immediate accept or a bus-wait stall, which separates the posted case from the bypass case for each combination.

A fill to depth four with the bus held off distinguishes the full stall from a plain wait. A bypass issued over a non-empty queue shows whether ordering is kept. The enable bit is then cleared mid-queue, and the queue is drained with distinct data per entry, which exposes any lost, reordered or altered entry.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = 4;

    typedef enum logic [1:0] {
        MEM_COPYBACK = 2'b00,
        MEM_WTHRU    = 2'b01,
        MEM_INHIB    = 2'b10,
        MEM_INHIB_B  = 2'b11
    } mem_mode_e;

    // posting rule: enabled and (write-through, or inhibited and imprecise)
    function automatic logic may_post(input logic en, input logic [1:0] mode,
                                      input logic precise);
        logic wt, ci;
        wt = (mode == MEM_WTHRU);
        ci = (mode == MEM_INHIB) || (mode == MEM_INHIB_B);
        return en && (wt || (ci && !precise));
    endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
    parameter int DEPTH = 4,
    parameter int EW    = 68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_ent,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_ent;
            st_d.wr           = step(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/pwb_steer.sv
module pwb_steer #(
    parameter int EW = 68
) (
    input  logic          en,
    input  logic          cpu_req,
    input  logic [1:0]    cpu_mode,
    input  logic          cpu_precise,
    input  logic [EW-1:0] cpu_ent,
    input  logic          q_empty,
    input  logic          q_full,
    input  logic [EW-1:0] q_head,
    input  logic          bus_ack,
    output logic          posted,
    output logic          push,
    output logic          pop,
    output logic          cpu_ready,
    output logic          bus_req,
    output logic [EW-1:0] bus_ent
);
    import pwb_pkg::*;

    always_comb begin
        posted    = may_post(en, cpu_mode, cpu_precise);
        push      = cpu_req && posted && !q_full;
        pop       = !q_empty && bus_ack;
        // bypass completes only when the bus takes it and nothing is queued ahead
        cpu_ready = posted ? !q_full : (q_empty && bus_ack);
        bus_req   = !q_empty || (cpu_req && !posted);
        bus_ent   = q_empty ? cpu_ent : q_head;
    end
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_data,
    input  logic [3:0]    cpu_be,
    input  logic [1:0]    cpu_mode,
    input  logic          cpu_precise,
    output logic          cpu_ready,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_data,
    output logic [3:0]    bus_be,
    input  logic          bus_ack,
    output logic          buf_empty
);
    import pwb_pkg::*;

    localparam int EW = AW + DATA_W + BE_W;

    typedef struct packed {
        logic en;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d.en = ctl_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [EW-1:0] cpu_ent, head_w, bus_ent;
    logic          push_w, pop_w, empty_w, full_w, posted_w;

    assign cpu_ent = {cpu_addr, cpu_data, cpu_be};

    pwb_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_w),
        .push_ent (cpu_ent),
        .pop      (pop_w),
        .head     (head_w),
        .empty    (empty_w),
        .full     (full_w)
    );

    pwb_steer #(.EW(EW)) u_steer (
        .en          (ctl_q.en),
        .cpu_req     (cpu_req),
        .cpu_mode    (cpu_mode),
        .cpu_precise (cpu_precise),
        .cpu_ent     (cpu_ent),
        .q_empty     (empty_w),
        .q_full      (full_w),
        .q_head      (head_w),
        .bus_ack     (bus_ack),
        .posted      (posted_w),
        .push        (push_w),
        .pop         (pop_w),
        .cpu_ready   (cpu_ready),
        .bus_req     (bus_req),
        .bus_ent     (bus_ent)
    );

    assign bus_addr  = bus_ent[EW-1 -: AW];
    assign bus_data  = bus_ent[BE_W +: DATA_W];
    assign bus_be    = bus_ent[BE_W-1:0];
    assign buf_empty = empty_w;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_ready,
    input logic          bus_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_data,
    input logic [3:0]    bus_be,
    input logic          buf_empty,
    input logic          full,
    input logic          push,
    input logic          posted
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R6
    bypass_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !posted && !buf_empty) |-> !cpu_ready);

    // R8
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !buf_empty) |=>
            ($stable(bus_addr) && $stable(bus_data) && $stable(bus_be) && bus_req));

    // R8
    keep_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack && !buf_empty) |=> !buf_empty);

    // R10
    pending_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_empty |-> bus_req);
endmodule

bind pwb_top pwb_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_be    (bus_be),
    .buf_empty (buf_empty),
    .full      (full_w),
    .push      (push_w),
    .posted    (posted_w)
);

// File: tb/tb_pwb_top.sv
`timescale 1ns/1ps
module tb_pwb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, ctl_en = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_data = '0;
    logic [3:0]    cpu_be = '0;
    logic [1:0]    cpu_mode = '0;
    logic          cpu_precise = 1'b0;
    logic          cpu_ready, bus_req, buf_empty;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_data;
    logic [3:0]    bus_be;
    logic          bus_ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit en_model = 0;

    always #2 clk = ~clk;

    pwb_top #(.AW(AW), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_be(cpu_be), .cpu_mode(cpu_mode), .cpu_precise(cpu_precise),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_be(bus_be), .bus_ack(bus_ack),
        .buf_empty(buf_empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int i);
        return 32'h1000_0000 + 32'(i * 16);
    endfunction
    function automatic logic [31:0] mk_data(input int i);
        return 32'hC0DE_0000 ^ 32'(i * 32'h0101_0101);
    endfunction
    function automatic logic [3:0] mk_be(input int i);
        return 4'(i * 5 + 1);
    endfunction

    function automatic bit exp_post(input bit en, input int mode, input bit prec);
        return en && ((mode == 1) || (mode >= 2 && !prec));
    endfunction

    task automatic set_en(input logic v);
        @(negedge clk); ctl_wr = 1'b1; ctl_en = v;
        @(negedge clk); ctl_wr = 1'b0;
        en_model = v;
    endtask

    task automatic present(input int i, input int mode, input bit prec);
        cpu_req = 1'b1; cpu_addr = mk_addr(i); cpu_data = mk_data(i);
        cpu_be = mk_be(i); cpu_mode = 2'(mode); cpu_precise = prec;
    endtask

    // bypass with empty queue: bus shows core write, ready follows ack
    task automatic bypass_write(input int i, input int mode, input bit prec, input string tag);
        @(negedge clk); present(i, mode, prec); bus_ack = 1'b0;
        #1;
        chk({tag, " bypass bus_req"}, bus_req, 1);
        chk({tag, " bypass addr"}, bus_addr, mk_addr(i));
        chk({tag, " bypass data"}, bus_data, mk_data(i));
        chk({tag, " bypass be"}, bus_be, mk_be(i));
        chk({tag, " bypass stall"}, cpu_ready, 0);
        @(negedge clk); bus_ack = 1'b1;
        #1;
        chk({tag, " bypass ready on ack"}, cpu_ready, 1);
        @(negedge clk); cpu_req = 1'b0; bus_ack = 1'b0;
        #1;
        chk({tag, " bypass not queued (R10)"}, buf_empty, 1);
    endtask

    task automatic post_write(input int i, input int mode, input bit prec, input string tag);
        @(negedge clk); present(i, mode, prec);
        #1;
        chk({tag, " post ready"}, cpu_ready, 1);
        @(negedge clk); cpu_req = 1'b0;
        #1;
        chk({tag, " post queued (R10)"}, buf_empty, 0);
    endtask

    task automatic drain_one(input int i, input string tag);
        @(negedge clk);
        #1;
        chk({tag, " drain req"}, bus_req, 1);
        chk({tag, " drain addr"}, bus_addr, mk_addr(i));
        chk({tag, " drain data"}, bus_data, mk_data(i));
        chk({tag, " drain be"}, bus_be, mk_be(i));
        bus_ack = 1'b1;
        @(negedge clk); bus_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 empty", buf_empty, 1);
        chk("R1 bus_req", bus_req, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 empty after release", buf_empty, 1);
        chk("R1 bus idle", bus_req, 0);

        // R3: enable clear after reset, every combination bypasses
        n = 0;
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++) begin
                bypass_write(n, m, p[0], "R1 R3 disabled");
                n++;
            end

        // R4 R5: enabled sweep of every mode and precision
        set_en(1'b1);
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++) begin
                if (exp_post(en_model, m, p[0])) begin
                    post_write(n, m, p[0], "R4 posted");
                    drain_one(n, "R4 R7");
                    #1; chk("R10 empty after drain", buf_empty, 1);
                end else begin
                    bypass_write(n, m, p[0], "R5 enabled bypass");
                end
                n++;
            end

        // R2: fill four entries with bus held off
        for (int k = 0; k < 4; k++) post_write(100 + k, (k % 2 == 0) ? 1 : 2, 1'b0, "R2 fill");
        @(negedge clk); present(200, 1, 1'b0);
        #1;
        chk("R2 full stall", cpu_ready, 0);
        chk("R7 head first", bus_addr, mk_addr(100));
        @(negedge clk); #1;
        chk("R2 still stalled", cpu_ready, 0);
        chk("R8 head stable", bus_data, mk_data(100));
        // R6: bypass over non-empty queue
        @(negedge clk); present(201, 2, 1'b1);
        #1;
        chk("R6 bypass held", cpu_ready, 0);
        chk("R6 bus shows head", bus_addr, mk_addr(100));
        @(negedge clk); cpu_req = 1'b0;
        // R9: disable with pending entries
        set_en(1'b0);
        #1; chk("R9 entries kept", buf_empty, 0);
        for (int k = 0; k < 4; k++) drain_one(100 + k, "R7 R9 order");
        #1; chk("R10 empty after full drain", buf_empty, 1);
        bypass_write(300, 1, 1'b0, "R9 R3 later bypass");

        // R6 R9: bypass requested while queue drains, issued after
        set_en(1'b1);
        post_write(400, 1, 1'b0, "R6 pre");
        @(negedge clk); present(401, 0, 1'b0); bus_ack = 1'b0;
        #1;
        chk("R6 held behind entry", cpu_ready, 0);
        chk("R6 head on bus", bus_addr, mk_addr(400));
        bus_ack = 1'b1;
        #1; chk("R6 ack drains not bypass", cpu_ready, 0);
        @(negedge clk); #1;
        chk("R6 bypass now on bus", bus_addr, mk_addr(401));
        chk("R6 bypass ready", cpu_ready, 1);
        @(negedge clk); cpu_req = 1'b0; bus_ack = 1'b0;
        #1; chk("R10 final empty", buf_empty, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule